// File: doc/BRIEF.md
# Nibble-RAM Cartridge Bank Controller

This block sits between a CPU's 16-bit address bus and a cartridge ROM. It also holds a small on-board work memory. The lower 16 KiB CPU window always maps to the first ROM bank. The upper 16 KiB window maps to a bank that software picks through a 4-bit bank register. The controller forms an 18-bit extended address that drives the external ROM directly. The ROM device itself lives outside the block.

Writes to the low control space, 0x0000 to 0x3FFF, reach one of two registers, and address bit 8 decides which one. With bit 8 clear the write goes to a RAM enable switch. With bit 8 set it goes to the ROM bank register.

The on-board memory holds 512 locations of 4 bits each, mapped at 0xA000 to 0xA1FF. It keeps only the low nibble of each byte written. A read returns the nibble with the upper four bits at zero, or 0xFF while the memory is switched off. Read data is registered: it appears one clock after the read strobe is sampled.

Top module: `nib_cart_ctrl`

## Requirements
- R1: For a CPU address in 0x0000–0x3FFF, rom_addr equals the CPU address zero-extended to 18 bits (bank 0).
- R2: For a CPU address in 0x4000–0x7FFF, rom_addr bits 17:14 hold the effective bank and bits 13:0 equal CPU address bits 13:0, so the bank stride is 0x4000.
- R3: A bank register value of 0 is used as bank 1 in the 0x4000–0x7FFF window, so the effective bank there is never 0.
- R4: A write with cpu_wr high to 0x0000–0x3FFF with address bit 8 set loads cpu_wdata[3:0] into the bank register at the next clock edge. cpu_wdata[7:4] is ignored.
- R5: A write to 0x0000–0x3FFF with address bit 8 clear goes to the RAM enable switch: 0x0A turns the memory on, 0x00 turns it off, and any other value leaves it unchanged. Such a write never changes the bank register, and a bank write never changes the enable switch.
- R6: While the memory is on, a write to 0xA000–0xA1FF stores cpu_wdata[3:0] at index cpu_addr[8:0]. While the memory is off, such writes are dropped.
- R7: A cycle with cpu_rd high and an address in 0xA000–0xA1FF sets ram_rdata at the next edge to {4'h0, stored nibble} when the memory is on, or to 0xFF when it is off. Reads at other addresses leave ram_rdata unchanged.
- R8: After a clock edge with rst_n low, the memory is off, the bank register is 0 (the upper window shows bank 1), and ram_rdata is 0xFF.
- R9: Writes to addresses outside 0x0000–0x3FFF and 0xA000–0xA1FF (for example 0x4000–0x7FFF or 0xA200) change neither register nor any memory location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one access per high cycle |
| cpu_rd | input | 1 | Read strobe, one access per high cycle |
| rom_addr | output | 18 | Extended ROM address (bank and offset) |
| ram_rdata | output | 8 | Registered read data from the on-board memory |

## Verification
The bench builds the block with its default parameters: a 4-bit bank register and 512 memory locations. With these values it can sweep all sixteen bank codes, including the zero-to-one substitution and bank 15 at the top of the 18-bit space. It can also reach both end locations of the memory and an address one past its end. The bench switches the memory on and off and writes rejected enable codes, so it observes every state of the enable switch through the registered read data.

// File: rtl/cbc_pkg.sv
// Package: shared constants and the decoded command type for the
// cartridge bank controller. Assumes a 16-bit CPU address bus.
package cbc_pkg;
    localparam int CPU_AW   = 16;            // CPU address width
    localparam int WIN_W    = 14;            // 16 KiB window offset width
    localparam int SEL_BIT  = 8;             // picks enable vs bank register
    localparam logic [7:0] EN_ON_CODE  = 8'h0A;
    localparam logic [7:0] EN_OFF_CODE = 8'h00;
    localparam logic [CPU_AW-1:0] RAM_BASE = 16'hA000;

    // One decoded CPU access
    typedef struct packed {
        logic en_wr;    // write to RAM enable switch
        logic bank_wr;  // write to bank register
        logic ram_wr;   // write to on-board memory range
        logic ram_rd;   // read of on-board memory range
    } cbc_cmd_t;
endpackage

// File: rtl/cbc_wr_decode.sv
// Access decoder: classifies each CPU strobe into one register or
// memory command. Assumes at most one of cpu_wr / cpu_rd per cycle
// and a memory depth that is a power of two aligned to RAM_BASE.
module cbc_wr_decode
    import cbc_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output cbc_cmd_t          cmd
);
    logic ctrl_space;
    logic ram_space;

    // Region decode of the address
    always_comb begin
        ctrl_space = (cpu_addr[CPU_AW-1:WIN_W] == '0);
        ram_space  = (cpu_addr[CPU_AW-1:IDX_W] == RAM_BASE[CPU_AW-1:IDX_W]);
    end

    // Strobe qualification into commands
    always_comb begin
        cmd.en_wr   = cpu_wr && ctrl_space && !cpu_addr[SEL_BIT];
        cmd.bank_wr = cpu_wr && ctrl_space &&  cpu_addr[SEL_BIT];
        cmd.ram_wr  = cpu_wr && ram_space;
        cmd.ram_rd  = cpu_rd && ram_space;
    end
endmodule

// File: rtl/cbc_bank_reg.sv
// Bank register: holds the selected upper-window bank and gives the
// effective bank with 0 replaced by 1. Synchronous active-low reset.
module cbc_bank_reg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank_eff
);
    logic [BANK_W-1:0] bank_q;

    // Load the bank code on a bank write
    always_ff @(posedge clk) begin
        if (!rst_n)    bank_q <= '0;
        else if (load) bank_q <= din;
    end

    // Substitute bank 1 for bank 0
    always_comb begin
        bank_eff = (bank_q == '0) ? BANK_W'(1) : bank_q;
    end

    // R4: the code written is the code held afterwards
    a_r4_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bank_q == $past(din));
    // R5/R9: without a bank write the register holds
    a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_q));
    // R3: effective bank is never zero
    a_r3_bank_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        bank_eff != '0);
endmodule

// File: rtl/cbc_ram_gate.sv
// RAM enable switch: turns the on-board memory on for the on code, off
// for the off code and ignores other data. Synchronous active-low reset.
module cbc_ram_gate
    import cbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic              ram_on
);
    logic hit_on;
    logic hit_off;

    // Recognise the two accepted codes
    always_comb begin
        hit_on  = (din == DATA_W'(EN_ON_CODE));
        hit_off = (din == DATA_W'(EN_OFF_CODE));
    end

    // Update the switch only on an accepted code
    always_ff @(posedge clk) begin
        if (!rst_n)                ram_on <= 1'b0;
        else if (wr && hit_on)     ram_on <= 1'b1;
        else if (wr && hit_off)    ram_on <= 1'b0;
    end

    // R5: on code turns the memory on
    a_r5_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && din == DATA_W'(8'h0A)) |=> ram_on);
    // R5: off code turns the memory off
    a_r5_turn_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && din == DATA_W'(8'h00)) |=> !ram_on);
    // R5: any other code, or no write, keeps the state
    a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || (din != DATA_W'(8'h0A) && din != DATA_W'(8'h00))) |=> $stable(ram_on));
endmodule

// File: rtl/cbc_nib_ram.sv
// Nibble memory: RAM_DEPTH locations of NIB_W bits with a registered
// read port. Reads while off give all ones; reads while on give the
// nibble zero-extended. Storage has no reset; the read register does.
module cbc_nib_ram #(
    parameter int RAM_DEPTH = 512,
    parameter int NIB_W     = 4,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_on,
    input  logic              wr,
    input  logic              rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [NIB_W-1:0] mem [RAM_DEPTH];

    // Store the low nibble while enabled
    always_ff @(posedge clk) begin
        if (rst_n && wr && ram_on) mem[idx] <= wdata[NIB_W-1:0];
    end

    // Register read data for a read in range
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '1;
        else if (rd) begin
            if (ram_on)    rdata <= {{(DATA_W-NIB_W){1'b0}}, mem[idx]};
            else           rdata <= '1;
        end
    end

    // R6: an enabled write is visible in the addressed location
    a_r6_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ram_on) |=> mem[$past(idx)] == $past(wdata[NIB_W-1:0]));
    // R7: a disabled read returns all ones
    a_r7_off_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ram_on) |=> rdata == '1);
    // R7: an enabled read has zero upper bits
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ram_on) |=> rdata[DATA_W-1:NIB_W] == '0);
    // R7: without a read the output holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/nib_cart_ctrl.sv
// Top: cartridge bank controller. Maps the lower CPU window to bank 0
// and the upper window to the selected bank, and hosts the nibble
// memory. Assumes the external ROM decodes rom_addr combinationally.
module nib_cart_ctrl
    import cbc_pkg::*;
#(
    parameter int BANK_W    = 4,
    parameter int RAM_DEPTH = 512,
    parameter int NIB_W     = 4,
    parameter int DATA_W    = 8,
    localparam int ROM_AW   = BANK_W + WIN_W,
    localparam int IDX_W    = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [DATA_W-1:0] ram_rdata
);
    cbc_cmd_t          cmd;
    logic [BANK_W-1:0] bank_eff;
    logic [BANK_W-1:0] win_bank;
    logic              ram_on;

    cbc_wr_decode #(.IDX_W(IDX_W)) dec_i (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cpu_rd   (cpu_rd),
        .cmd      (cmd)
    );

    cbc_bank_reg #(.BANK_W(BANK_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd.bank_wr),
        .din      (cpu_wdata[BANK_W-1:0]),
        .bank_eff (bank_eff)
    );

    cbc_ram_gate #(.DATA_W(DATA_W)) gate_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmd.en_wr),
        .din    (cpu_wdata),
        .ram_on (ram_on)
    );

    cbc_nib_ram #(
        .RAM_DEPTH (RAM_DEPTH),
        .NIB_W     (NIB_W),
        .DATA_W    (DATA_W)
    ) ram_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ram_on (ram_on),
        .wr     (cmd.ram_wr),
        .rd     (cmd.ram_rd),
        .idx    (cpu_addr[IDX_W-1:0]),
        .wdata  (cpu_wdata),
        .rdata  (ram_rdata)
    );

    // Pick bank 0 for the lower window, selected bank for the upper
    always_comb begin
        win_bank = cpu_addr[WIN_W] ? bank_eff : '0;
        rom_addr = {win_bank, cpu_addr[WIN_W-1:0]};
    end

    // R1: the lower window never carries a bank
    a_r1_low_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1:WIN_W] == 2'b00) |-> rom_addr[ROM_AW-1:WIN_W] == '0);
    // R3: the upper window never shows bank 0
    a_r3_upper_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1:WIN_W] == 2'b01) |-> rom_addr[ROM_AW-1:WIN_W] != '0);
    // R2: a bank write shows up in the upper window
    a_r2_bank_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.bank_wr && cpu_wdata[BANK_W-1:0] != '0 && $stable(cpu_addr))
        |=> (cpu_addr[WIN_W] -> rom_addr[ROM_AW-1:WIN_W] == $past(cpu_wdata[BANK_W-1:0])));
endmodule

// File: tb/nib_cart_ctrl_tb_top.sv
`timescale 1ns/1ps
module nib_cart_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [17:0] rom_addr;
    logic [7:0]  ram_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    nib_cart_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .rom_addr  (rom_addr),
        .ram_rdata (ram_rdata)
    );

    // External ROM model: byte content derived from the full address
    function automatic logic [7:0] rom_byte(input logic [17:0] a);
        return a[7:0] ^ {a[17:14], a[11:8]};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Driver: push expected read data, then issue the read
    task automatic ram_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        exp_item_t it;
        it.exp = exp; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    // ROM window check against bench-computed address
    task automatic rom_check(input logic [15:0] a, input logic [17:0] exp, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
        total++;
        if (rom_addr !== exp || rom_byte(rom_addr) !== rom_byte(exp)) begin
            bad++;
            $display("FAIL %s: actual=%05h expected=%05h", tag, rom_addr, exp);
        end
    endtask

    // Monitor: after a sampled in-range read, compare at the next falling edge
    always @(posedge clk) begin
        if (rst_n && cpu_rd && cpu_addr[15:9] == 7'h50) begin
            @(negedge clk);
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R7: actual=%02h expected=none queued", ram_rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check8(it.tag, ram_rdata, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        check8("R8 rdata after reset", ram_rdata, 8'hFF);
        rom_check(16'h4123, 18'h04123, "R8 R3 bank 1 after reset");
        rom_check(16'h1234, 18'h01234, "R1 low window");
        ram_read(16'hA010, 8'hFF, "R8 R7 memory off after reset");

        // R4: bank load with upper data bits ignored
        cpu_write(16'h2100, 8'hF5);
        rom_check(16'h7FFF, 18'h17FFF, "R2 R4 bank 5 top of window");
        rom_check(16'h0ABC, 18'h00ABC, "R1 low window with bank 5");

        // R5: bit 8 clear, unknown code: no enable, bank kept
        cpu_write(16'h2000, 8'h07);
        rom_check(16'h4000, 18'h14000, "R5 bank unchanged by enable write");
        ram_read(16'hA000, 8'hFF, "R5 other code keeps memory off");

        // R5/R6/R7: turn on, store nibbles, read back
        cpu_write(16'h0000, 8'h0A);
        rom_check(16'h5555, 18'h15555, "R5 bank unchanged by on code");
        cpu_write(16'hA000, 8'h3C);
        cpu_write(16'hA1FF, 8'hF7);
        ram_read(16'hA000, 8'h0C, "R6 R7 low nibble at first location");
        ram_read(16'hA1FF, 8'h07, "R6 R7 low nibble at last location");

        // R5: other code keeps memory on
        cpu_write(16'h0000, 8'h55);
        ram_read(16'hA000, 8'h0C, "R5 other code keeps memory on");

        // R3/R5: bank write of 0 uses bank 1 and leaves enable alone
        cpu_write(16'h0100, 8'h00);
        rom_check(16'h4000, 18'h04000, "R3 bank 0 maps to bank 1");
        ram_read(16'hA000, 8'h0C, "R5 bank write leaves memory on");

        // R9: writes outside decoded ranges
        cpu_write(16'h5000, 8'h0A);
        cpu_write(16'h4100, 8'h03);
        cpu_write(16'hA200, 8'h05);
        cpu_write(16'hC000, 8'h00);
        rom_check(16'h6000, 18'h06000, "R9 bank unchanged by stray writes");
        ram_read(16'hA000, 8'h0C, "R9 no alias one past the end");

        // R7: read outside range leaves rdata unchanged
        ram_read(16'hA1FF, 8'h07, "R7 prime read data");
        @(negedge clk);
        cpu_addr = 16'h4000; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        check8("R7 out-of-range read holds rdata", ram_rdata, 8'h07);

        // R6: disabled writes dropped; R7 disabled read
        cpu_write(16'h1000, 8'h00);
        ram_read(16'hA000, 8'hFF, "R7 memory off reads ones");
        cpu_write(16'hA000, 8'h09);
        cpu_write(16'h0000, 8'h0A);
        ram_read(16'hA000, 8'h0C, "R6 write while off dropped");

        // R2/R4: sweep all bank codes
        for (int b = 0; b < 16; b++) begin
            logic [3:0] eb;
            eb = (b == 0) ? 4'd1 : 4'(b);
            cpu_write(16'h3F00, 8'(b) | 8'hA0);
            rom_check(16'h6ABC, {eb, 14'h2ABC}, "R2 R4 bank sweep");
        end

        // R6: pattern across the memory
        for (int i = 0; i < 8; i++) begin
            cpu_write(16'hA000 + 16'(i * 61), 8'(i * 37 + 11));
        end
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            v = 8'(i * 37 + 11);
            ram_read(16'hA000 + 16'(i * 61), {4'h0, v[3:0]}, "R6 R7 pattern readback");
        end

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R7: actual=%0d pending expected=0", sb_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule